// File: doc/BRIEF.md
# Edge-Triggered Counter Snapshot Unit

This block sits beside a free-running 16-bit counter and records the counter's value at the moment an external pin makes a chosen transition. The pin first passes through a two-stage synchronizer. When a capture is accepted, the counter value lands in a snapshot register and a pending flag goes high. If the interrupt enable is set, the flag drives an interrupt request.

Two options shape the behaviour at run time. An optional agreement filter accepts a new pin level only after four consecutive synchronized samples agree on it. This suppresses short glitches and makes capture exactly four clocks later than on the direct path. A separate input tells the unit that the snapshot register is being used as the counter's top value. While that input is high, the pin is ignored and the register and flag keep their contents. Software clears the flag with a write-one strobe, or the interrupt controller clears it with an acknowledge.

Top module: `edge_capture_unit`

## Requirements
- R1: While reset is asserted, `capReg` reads 0, `capFlag` reads 0 and `irq` reads 0.
- R2: With the filter off, a qualifying pin transition that is present at clock edge k is recorded at edge k+2. `capReg` then holds the `cntVal` that was presented to that edge.
- R3: With the filter on, the accepted pin level changes only after four consecutive synchronized samples hold the new level. A pin excursion that lasts three clocks causes no capture.
- R4: With the filter on, a qualifying transition present at edge k is recorded at edge k+6, four clocks later than on the direct path.
- R5: `edgeRise` = 1 selects captures on low-to-high transitions, and `edgeRise` = 0 selects captures on high-to-low transitions. The opposite transition changes neither `capReg` nor `capFlag`.
- R6: Each capture copies `cntVal` into `capReg` and sets `capFlag`. A capture while `capFlag` is already set overwrites `capReg` and leaves the flag set.
- R7: `irq` is high exactly when `capFlag` is 1 and `irqEn` is 1.
- R8: A one on `flagClr` or on `irqAck` clears `capFlag` at the next edge. If a capture is accepted on that same edge, the flag stays set.
- R9: While `topIsCap` is 1, pin transitions are ignored. `capReg` and `capFlag` stay unchanged, and no capture appears after `topIsCap` returns to 0 with the pin held steady.
- R10: Changing `edgeRise` while the pin is steady causes no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| capPin | input | 1 | Asynchronous external capture pin |
| cntVal | input | 16 | Current value of the running counter |
| edgeRise | input | 1 | 1: capture on rising transition, 0: on falling |
| filterEn | input | 1 | Enables the four-sample agreement filter |
| irqEn | input | 1 | Capture interrupt enable |
| flagClr | input | 1 | Write-one strobe that clears the flag |
| irqAck | input | 1 | Interrupt acknowledge, clears the flag |
| topIsCap | input | 1 | Snapshot register serves as counter top; blocks capture |
| capReg | output | 16 | Snapshot register readback |
| capFlag | output | 1 | Capture pending flag |
| irq | output | 1 | Interrupt request |

## Verification
A capture can be accepted on the same clock edge that a flag clear arrives. The bench provokes this by raising `flagClr` for exactly the cycle in which the direct path's capture lands, two edges after the pin change. It then judges that the flag is still set and that `capReg` holds the new counter value. The scoreboard also confirms that the overwrite case keeps the flag high and that the acknowledge path alone brings it low.

// File: rtl/edge_cap_pkg.sv
package edge_cap_pkg;
  typedef struct packed {
    logic grab;   // accept a capture this cycle
    logic drop;   // request flag clear this cycle
  } capCtrl_t;
endpackage

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import edge_cap_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     capPin,
  input  logic     edgeRise,
  input  logic     filterEn,
  input  logic     topIsCap,
  input  logic     flagClr,
  input  logic     irqAck,
  output capCtrl_t ctl
);
  localparam int LAST_SYNC = SYNC_STAGES - 1;
  localparam int LAST_HIST = FILT_LEN - 1;

  // synchronizer chain
  logic [SYNC_STAGES-1:0] syncQ;
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[g] <= 1'b0;
          else       syncQ[g] <= capPin;
        end
      end else begin : gRest
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[g] <= 1'b0;
          else       syncQ[g] <= syncQ[g-1];
        end
      end
    end
  endgenerate

  logic pinSync;
  assign pinSync = syncQ[LAST_SYNC];

  // direct path
  logic rawPrev;
  always_ff @(posedge clk) begin
    if (!rstN) rawPrev <= 1'b0;
    else       rawPrev <= pinSync;
  end

  logic rawEdge;
  assign rawEdge = pinSync ^ rawPrev;

  // agreement filter
  logic [FILT_LEN-1:0] hist;
  logic                filtLvl;
  logic                filtNext;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hist    <= '0;
      filtLvl <= 1'b0;
    end else begin
      hist    <= {hist[LAST_HIST-1:0], pinSync};
      filtLvl <= filtNext;
    end
  end

  always_comb begin
    if (&hist)       filtNext = 1'b1;
    else if (~|hist) filtNext = 1'b0;
    else             filtNext = filtLvl;
  end

  logic filtEdge;
  assign filtEdge = filtNext ^ filtLvl;

  // path choice and edge qualification
  logic newLvl, anyEdge, wanted;
  always_comb begin
    newLvl   = filterEn ? filtNext : pinSync;
    anyEdge  = filterEn ? filtEdge : rawEdge;
    wanted   = edgeRise ? newLvl : ~newLvl;
    ctl.grab = anyEdge & wanted & ~topIsCap;
    ctl.drop = flagClr | irqAck;
  end
endmodule

// File: rtl/cap_data.sv
module cap_data
  import edge_cap_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  capCtrl_t     ctl,
  input  logic [W-1:0] cntVal,
  input  logic         irqEn,
  output logic [W-1:0] capReg,
  output logic         capFlag,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capReg  <= '0;
      capFlag <= 1'b0;
    end else begin
      if (ctl.grab) capReg <= cntVal;
      if (ctl.grab)      capFlag <= 1'b1;
      else if (ctl.drop) capFlag <= 1'b0;
    end
  end

  assign irq = capFlag & irqEn;
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import edge_cap_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         capPin,
  input  logic [W-1:0] cntVal,
  input  logic         edgeRise,
  input  logic         filterEn,
  input  logic         irqEn,
  input  logic         flagClr,
  input  logic         irqAck,
  input  logic         topIsCap,
  output logic [W-1:0] capReg,
  output logic         capFlag,
  output logic         irq
);
  capCtrl_t ctl;

  cap_ctrl #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .capPin(capPin), .edgeRise(edgeRise),
    .filterEn(filterEn), .topIsCap(topIsCap), .flagClr(flagClr),
    .irqAck(irqAck), .ctl(ctl)
  );

  cap_data #(.W(W)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cntVal(cntVal), .irqEn(irqEn),
    .capReg(capReg), .capFlag(capFlag), .irq(irq)
  );
endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         irqEn,
  input logic         flagClr,
  input logic         irqAck,
  input logic         topIsCap,
  input logic [W-1:0] capReg,
  input logic         capFlag,
  input logic         irq
);
  // a changed snapshot always comes with the flag set
  assert_snap_sets_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(capReg) |-> capFlag);

  // blocked capture keeps the register
  assert_top_blocks_R9: assert property (@(posedge clk) disable iff (!rstN)
    topIsCap |=> $stable(capReg));

  // flag only falls after a clear request
  assert_fall_needs_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(capFlag) |-> $past(flagClr || irqAck));

  // flag holds without a clear request
  assert_flag_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (capFlag && !flagClr && !irqAck) |=> capFlag);

  // request needs flag and enable
  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (capFlag && irqEn));
endmodule

bind edge_capture_unit cap_checker #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .irqEn(irqEn), .flagClr(flagClr), .irqAck(irqAck),
  .topIsCap(topIsCap), .capReg(capReg), .capFlag(capFlag), .irq(irq)
);

// File: tb/edge_capture_unit_bench.sv
module edge_capture_unit_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        capPin;
  logic [15:0] cntVal;
  logic        edgeRise, filterEn, irqEn, flagClr, irqAck, topIsCap;
  logic [15:0] capReg;
  logic        capFlag, irq;

  int total = 0;
  int bad = 0;
  int tick = 0;
  bit finished = 1'b0;
  logic [15:0] expQ[$];
  logic [15:0] lastExp = 16'h0;

  always #10 clk = ~clk;  // 50 MHz

  edge_capture_unit u_edge_capture_unit (
    .clk(clk), .rstN(rstN), .capPin(capPin), .cntVal(cntVal),
    .edgeRise(edgeRise), .filterEn(filterEn), .irqEn(irqEn),
    .flagClr(flagClr), .irqAck(irqAck), .topIsCap(topIsCap),
    .capReg(capReg), .capFlag(capFlag), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: advance at the falling edge, counter follows tick
  task automatic step();
    @(negedge clk);
    tick++;
    cntVal = tick[15:0];
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // driver: change the pin and predict the snapshot
  task automatic setPin(input bit v, input bit hit);
    logic [15:0] e;
    step();
    capPin = v;
    if (hit) begin
      e = tick[15:0] + (filterEn ? 16'd6 : 16'd2);
      expQ.push_back(e);
      lastExp = e;
    end
  endtask

  task automatic pulseClr();
    step(); flagClr = 1'b1;
    step(); flagClr = 1'b0;
  endtask

  // monitor: scoreboard pop on every new capture
  logic [15:0] monReg = 16'h0;
  logic        monFlag = 1'b0;
  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      if (capReg !== monReg || (capFlag && !monFlag)) begin
        if (expQ.size() == 0) begin
          chk("R5/R9 unexpected capture", int'(capReg), int'(monReg));
        end else begin
          logic [15:0] e;
          e = expQ.pop_front();
          chk("R2/R4/R6 snapshot", int'(capReg), int'(e));
        end
      end
    end
    monReg  = capReg;
    monFlag = capFlag;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; capPin = 1'b0; cntVal = 16'h0; edgeRise = 1'b1;
    filterEn = 1'b0; irqEn = 1'b0; flagClr = 1'b0; irqAck = 1'b0;
    topIsCap = 1'b0;
    waitn(3);
    chk("R1 capReg", int'(capReg), 0);
    chk("R1 capFlag", int'(capFlag), 0);
    chk("R1 irq", int'(irq), 0);
    rstN = 1'b1;
    waitn(5);

    // R2 R5: direct rising capture
    setPin(1'b1, 1'b1); waitn(10);
    chk("R6 flag set", int'(capFlag), 1);
    pulseClr(); step();
    chk("R8 write-one clear", int'(capFlag), 0);

    // R5: falling ignored when rising selected
    setPin(1'b0, 1'b0); waitn(10);
    chk("R5 falling ignored flag", int'(capFlag), 0);
    chk("R5 falling ignored reg", int'(capReg), int'(lastExp));

    // R5: falling selected
    edgeRise = 1'b0; step();
    setPin(1'b1, 1'b0); waitn(10);
    chk("R5 rising ignored", int'(capFlag), 0);
    setPin(1'b0, 1'b1); waitn(10);
    chk("R5 falling capture flag", int'(capFlag), 1);
    pulseClr(); waitn(2);

    // R10: edge select change alone
    edgeRise = 1'b1; waitn(5);
    edgeRise = 1'b0; waitn(5);
    edgeRise = 1'b1; waitn(5);
    chk("R10 no capture flag", int'(capFlag), 0);
    chk("R10 no capture reg", int'(capReg), int'(lastExp));

    // R4: filtered rising capture, four clocks later
    filterEn = 1'b1; waitn(10);
    setPin(1'b1, 1'b1); waitn(12);
    chk("R4 filtered flag", int'(capFlag), 1);
    pulseClr(); waitn(2);

    // R3: three-clock dip is rejected by the filter
    setPin(1'b0, 1'b0); step(); step();
    setPin(1'b1, 1'b0); waitn(12);
    chk("R3 glitch flag", int'(capFlag), 0);
    chk("R3 glitch reg", int'(capReg), int'(lastExp));

    // R7 and R6 overwrite
    filterEn = 1'b0; irqEn = 1'b1; waitn(10);
    setPin(1'b0, 1'b0); waitn(10);
    setPin(1'b1, 1'b1); waitn(10);
    chk("R7 irq high", int'(irq), 1);
    irqEn = 1'b0; step();
    chk("R7 irq masked", int'(irq), 0);
    irqEn = 1'b1;
    setPin(1'b0, 1'b0); waitn(10);
    setPin(1'b1, 1'b1); waitn(10);
    chk("R6 overwrite flag", int'(capFlag), 1);
    chk("R6 overwrite reg", int'(capReg), int'(lastExp));
    step(); irqAck = 1'b1;
    step(); irqAck = 1'b0;
    step();
    chk("R8 ack clears", int'(capFlag), 0);
    chk("R7 irq low", int'(irq), 0);

    // R8: clear and capture on the same edge
    setPin(1'b0, 1'b0); waitn(10);
    setPin(1'b1, 1'b1); waitn(10);
    setPin(1'b0, 1'b0); waitn(10);
    setPin(1'b1, 1'b1);   // pin change, capture lands two edges later
    step();
    step(); flagClr = 1'b1;
    step(); flagClr = 1'b0;
    chk("R8 set wins flag", int'(capFlag), 1);
    chk("R8 set wins reg", int'(capReg), int'(lastExp));
    waitn(3); pulseClr(); waitn(2);

    // R9: capture register used as top
    topIsCap = 1'b1; waitn(3);
    setPin(1'b0, 1'b0); waitn(10);
    setPin(1'b1, 1'b0); waitn(10);
    chk("R9 blocked flag", int'(capFlag), 0);
    chk("R9 blocked reg", int'(capReg), int'(lastExp));
    topIsCap = 1'b0; waitn(10);
    chk("R9 no late capture", int'(capFlag), 0);

    waitn(5);
    chk("R6 scoreboard drained", expQ.size(), 0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule